// File: doc/BRIEF.md
# Indexed Rotate, Shift and Bit-Operation Unit

This block carries out the byte-wide rotate, shift, bit-test, bit-set and bit-clear operations of an 8-bit processor's bit-manipulation opcode group. An operation is started with a one-cycle `start_i` pulse that presents the final opcode byte, a two-bit prefix code, a displacement byte, the incoming carry and the current values of the HL, IX and IY pointer registers. The operand is either a general register, read through a combinational read port, or a byte in memory. Memory is reached through a synchronous port: read data arrives on the cycle after the read enable.

In the plain form, the low three opcode bits pick a register or the byte at HL. In the indexed form, the operand is always the memory byte at IX or IY plus the sign-extended displacement. After the modified byte is written back, it is also copied into the register named by the low opcode bits, unless those bits name memory. The register copy comes from the value the unit computed, not from a second memory read. Because of this, it is correct even when the memory ignores the write.

The operation runs as a fixed sequence: address, read, execute, memory write, register write. A single-cycle `done_o` pulse ends it, and `busy_o` blocks new starts until then. Besides the usual left shift that fills with zero, the shift set has a left shift that fills bit 0 with one.

Top module: `rsb_exec_unit`

## Requirements
- R1: Opcode bits 7:6 = 00 select a shift or rotate, chosen by bits 5:3: 000 rotate left circular, 001 rotate right circular, 010 rotate left through carry, 011 rotate right through carry, 100 arithmetic left (fill 0), 101 arithmetic right (keep bit 7), 110 left shift filling bit 0 with 1, 111 logical right. `flag_c_o` takes the bit shifted out, and `c_i` is the carry that the through-carry rotates shift in.
- R2: After a shift or rotate, `flag_z_o` is 1 exactly when the result is zero. After a bit test, `flag_z_o` is the inverse of the tested bit. Bit tests leave `flag_c_o` unchanged.
- R3: With prefix 00, opcode bits 2:0 select the operand: 000 B, 001 C, 010 D, 011 E, 100 H, 101 L, 111 A, read and then written back to the same register. 110 selects the memory byte at HL; the displacement is ignored and no register is written.
- R4: Prefix 01 addresses memory at IX, and prefix 10 at IY, plus the displacement sign-extended to 16 bits, with the sum wrapping modulo 65536.
- R5: In the indexed form, the result is written to memory. It is also written to the register coded by bits 2:0 (same coding as R3), except when bits 2:0 = 110, which gives no register write.
- R6: Each memory-operand operation reads memory exactly once. The register copy equals the computed result even when the memory discards the write.
- R7: Opcode bits 7:6 = 11 set, and bits 7:6 = 10 clear, the bit numbered by bits 5:3. The result follows the same write and copy rules as the shifts.
- R8: A bit test (bits 7:6 = 01) writes neither memory nor a register. In the indexed form, all eight values of bits 2:0 give the same result.
- R9: The memory read comes before the memory write, and the memory write comes before the register write. `done_o` is high for exactly one cycle, directly after the last write.
- R10: A `start_i` seen while `busy_o` is high is ignored.
- R11: During and right after reset, `busy_o`, `done_o` and both write enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted when idle |
| op_i | input | 8 | Final opcode byte |
| pfx_i | input | 2 | Prefix: 00 none, 01 IX, 10 IY |
| disp_i | input | DISP_W | Signed displacement byte |
| hl_i | input | ADDR_W | HL pointer value |
| ix_i | input | ADDR_W | IX index value |
| iy_i | input | ADDR_W | IY index value |
| c_i | input | 1 | Carry in for the through-carry rotates |
| rf_rd_sel_o | output | SEL_W | Register read select (from op_i) |
| rf_rd_data_i | input | DATA_W | Register read data |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_rd_en_o | output | 1 | Memory read enable |
| mem_rd_data_i | input | DATA_W | Memory read data, one cycle after enable |
| mem_wr_en_o | output | 1 | Memory write enable |
| mem_wr_data_o | output | DATA_W | Memory write data |
| rf_wr_en_o | output | 1 | Register write enable |
| rf_wr_sel_o | output | SEL_W | Register write select |
| rf_wr_data_o | output | DATA_W | Register write data |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| flag_c_o | output | 1 | Carry flag |
| flag_z_o | output | 1 | Zero flag |

## Verification
The assertions assume three things: `pfx_i` only ever carries 00, 01 or 10; the read data follows the read enable by exactly one cycle; and the reset is asserted from time zero. The bench keeps to these assumptions. It drives only the three legal prefix codes. Its memory model registers read data on the clock edge after each enable. It holds reset low across the first edges. It changes inputs only on falling edges, so every start is taken on a clean rising edge.

// File: rtl/rsb_pkg.sv
package rsb_pkg;

   typedef enum logic [1:0] {
      PFX_NONE = 2'b00,
      PFX_IX   = 2'b01,
      PFX_IY   = 2'b10
   } pfx_e;

   typedef enum logic [1:0] {
      GRP_SHIFT = 2'b00,
      GRP_TEST  = 2'b01,
      GRP_CLR   = 2'b10,
      GRP_SETB  = 2'b11
   } grp_e;

   typedef enum logic [2:0] {
      SH_RLC = 3'b000,
      SH_RRC = 3'b001,
      SH_RL  = 3'b010,
      SH_RR  = 3'b011,
      SH_SLA = 3'b100,
      SH_SRA = 3'b101,
      SH_SLF = 3'b110,
      SH_SRL = 3'b111
   } shf_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_READ,
      ST_EXEC,
      ST_WMEM,
      ST_WREG,
      ST_DONE
   } st_e;

   localparam logic [2:0] SEL_MEM = 3'b110;

endpackage

// File: rtl/rsb_alu.sv
module rsb_alu import rsb_pkg::*; #(
   parameter int DATA_W = 8
) (
   input  logic [7:0]        op_i,
   input  logic [DATA_W-1:0] val_i,
   input  logic              c_i,
   output logic [DATA_W-1:0] res_o,
   output logic              c_o,
   output logic              z_o,
   output logic              c_upd_o,
   output logic              z_upd_o
);
   localparam int IDX_W = $clog2(DATA_W);
   localparam int MSB   = DATA_W - 1;

   logic [DATA_W-1:0] bit_mask;

   generate
      for (genvar g = 0; g < DATA_W; g++) begin : g_mask
         assign bit_mask[g] = (op_i[3 +: IDX_W] == IDX_W'(g));
      end
   endgenerate

   always_comb begin
      res_o   = val_i;
      c_o     = c_i;
      z_o     = 1'b0;
      c_upd_o = 1'b0;
      z_upd_o = 1'b0;
      case (op_i[7:6])
         GRP_SHIFT: begin
            c_upd_o = 1'b1;
            z_upd_o = 1'b1;
            case (op_i[5:3])
               SH_RLC:  begin c_o = val_i[MSB]; res_o = {val_i[MSB-1:0], val_i[MSB]}; end
               SH_RRC:  begin c_o = val_i[0];   res_o = {val_i[0], val_i[MSB:1]};     end
               SH_RL:   begin c_o = val_i[MSB]; res_o = {val_i[MSB-1:0], c_i};        end
               SH_RR:   begin c_o = val_i[0];   res_o = {c_i, val_i[MSB:1]};          end
               SH_SLA:  begin c_o = val_i[MSB]; res_o = {val_i[MSB-1:0], 1'b0};       end
               SH_SRA:  begin c_o = val_i[0];   res_o = {val_i[MSB], val_i[MSB:1]};   end
               SH_SLF:  begin c_o = val_i[MSB]; res_o = {val_i[MSB-1:0], 1'b1};       end
               default: begin c_o = val_i[0];   res_o = {1'b0, val_i[MSB:1]};         end
            endcase
            z_o = (res_o == '0);
         end
         GRP_TEST: begin
            z_upd_o = 1'b1;
            z_o     = ~|(val_i & bit_mask);
         end
         GRP_CLR:  res_o = val_i & ~bit_mask;
         default:  res_o = val_i | bit_mask;
      endcase
   end

endmodule

// File: rtl/rsb_agen.sv
module rsb_agen #(
   parameter int ADDR_W = 16,
   parameter int DISP_W = 8
) (
   input  logic [ADDR_W-1:0] base_i,
   input  logic [DISP_W-1:0] disp_i,
   input  logic              idx_i,
   output logic [ADDR_W-1:0] addr_o
);
   localparam int EXT_W = ADDR_W - DISP_W;

   logic [ADDR_W-1:0] offs;

   assign offs   = idx_i ? {{EXT_W{disp_i[DISP_W-1]}}, disp_i} : '0;
   assign addr_o = base_i + offs;

endmodule

// File: rtl/rsb_seq.sv
module rsb_seq import rsb_pkg::*; #(
   parameter bit ADDR_PIPE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic mem_op_i,
   input  logic rf_wr_i,
   input  logic test_i,
   output st_e  state_o,
   output logic accept_o
);
   st_e state_q, state_d;

   assign state_o  = state_q;
   assign accept_o = (state_q == ST_IDLE) && start_i;

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE: if (start_i) begin
            if (!mem_op_i)     state_d = ST_EXEC;
            else if (ADDR_PIPE) state_d = ST_ADDR;
            else               state_d = ST_READ;
         end
         ST_ADDR: state_d = ST_READ;
         ST_READ: state_d = ST_EXEC;
         ST_EXEC: begin
            if (test_i)        state_d = ST_DONE;
            else if (mem_op_i) state_d = ST_WMEM;
            else               state_d = ST_WREG;
         end
         ST_WMEM: state_d = rf_wr_i ? ST_WREG : ST_DONE;
         ST_WREG: state_d = ST_DONE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

endmodule

// File: rtl/rsb_exec_unit.sv
module rsb_exec_unit import rsb_pkg::*; #(
   parameter int ADDR_W    = 16,
   parameter int DISP_W    = 8,
   parameter int DATA_W    = 8,
   parameter int SEL_W     = 3,
   parameter bit ADDR_PIPE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [7:0]        op_i,
   input  logic [1:0]        pfx_i,
   input  logic [DISP_W-1:0] disp_i,
   input  logic [ADDR_W-1:0] hl_i,
   input  logic [ADDR_W-1:0] ix_i,
   input  logic [ADDR_W-1:0] iy_i,
   input  logic              c_i,
   output logic [SEL_W-1:0]  rf_rd_sel_o,
   input  logic [DATA_W-1:0] rf_rd_data_i,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic              mem_rd_en_o,
   input  logic [DATA_W-1:0] mem_rd_data_i,
   output logic              mem_wr_en_o,
   output logic [DATA_W-1:0] mem_wr_data_o,
   output logic              rf_wr_en_o,
   output logic [SEL_W-1:0]  rf_wr_sel_o,
   output logic [DATA_W-1:0] rf_wr_data_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              flag_c_o,
   output logic              flag_z_o
);
   generate
      if (DATA_W != 8)      begin : g_chk_data $error("DATA_W must be 8");          end
      if (SEL_W != 3)       begin : g_chk_sel  $error("SEL_W must be 3");           end
      if (ADDR_W <= DISP_W) begin : g_chk_addr $error("ADDR_W must exceed DISP_W"); end
   endgenerate

   st_e               state;
   logic              accept;
   logic [7:0]        op_q;
   pfx_e              pfx_q;
   logic [DISP_W-1:0] disp_q;
   logic [ADDR_W-1:0] base_q;
   logic [DATA_W-1:0] opnd_q;
   logic              cin_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] res_q;

   pfx_e              pfx_in;
   logic [ADDR_W-1:0] base_live;
   logic [7:0]        dec_op;
   pfx_e              dec_pfx;
   logic              dec_mem_op;
   logic              dec_rf_wr;
   logic              dec_test;

   logic [ADDR_W-1:0] addr_calc;
   logic              addr_load;

   logic [DATA_W-1:0] alu_in;
   logic [DATA_W-1:0] alu_res;
   logic              alu_c;
   logic              alu_z;
   logic              alu_c_upd;
   logic              alu_z_upd;

   // decode from the live opcode while idle, from the captured one while busy
   assign pfx_in     = pfx_e'(pfx_i);
   assign base_live  = (pfx_in == PFX_NONE) ? hl_i : ((pfx_in == PFX_IX) ? ix_i : iy_i);
   assign busy_o     = (state != ST_IDLE);
   assign dec_op     = busy_o ? op_q  : op_i;
   assign dec_pfx    = busy_o ? pfx_q : pfx_in;
   assign dec_mem_op = (dec_pfx != PFX_NONE) || (dec_op[2:0] == SEL_MEM);
   assign dec_rf_wr  = (dec_op[2:0] != SEL_MEM);
   assign dec_test   = (dec_op[7:6] == GRP_TEST);

   rsb_seq #(.ADDR_PIPE(ADDR_PIPE)) seq_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .mem_op_i (dec_mem_op),
      .rf_wr_i  (dec_rf_wr),
      .test_i   (dec_test),
      .state_o  (state),
      .accept_o (accept)
   );

   generate
      if (ADDR_PIPE) begin : g_addr_pipe
         rsb_agen #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) agen_i (
            .base_i (base_q),
            .disp_i (disp_q),
            .idx_i  (pfx_q != PFX_NONE),
            .addr_o (addr_calc)
         );
         assign addr_load = (state == ST_ADDR);
      end else begin : g_addr_direct
         rsb_agen #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) agen_i (
            .base_i (base_live),
            .disp_i (disp_i),
            .idx_i  (pfx_in != PFX_NONE),
            .addr_o (addr_calc)
         );
         assign addr_load = accept;
      end
   endgenerate

   assign alu_in = dec_mem_op ? mem_rd_data_i : opnd_q;

   rsb_alu #(.DATA_W(DATA_W)) alu_i (
      .op_i    (op_q),
      .val_i   (alu_in),
      .c_i     (cin_q),
      .res_o   (alu_res),
      .c_o     (alu_c),
      .z_o     (alu_z),
      .c_upd_o (alu_c_upd),
      .z_upd_o (alu_z_upd)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q     <= '0;
         pfx_q    <= PFX_NONE;
         disp_q   <= '0;
         base_q   <= '0;
         opnd_q   <= '0;
         cin_q    <= 1'b0;
         addr_q   <= '0;
         res_q    <= '0;
         flag_c_o <= 1'b0;
         flag_z_o <= 1'b0;
      end else begin
         if (accept) begin
            op_q   <= op_i;
            pfx_q  <= pfx_in;
            disp_q <= disp_i;
            base_q <= base_live;
            opnd_q <= rf_rd_data_i;
            cin_q  <= c_i;
         end
         if (addr_load) addr_q <= addr_calc;
         if (state == ST_EXEC) begin
            res_q <= alu_res;
            if (alu_c_upd) flag_c_o <= alu_c;
            if (alu_z_upd) flag_z_o <= alu_z;
         end
      end
   end

   assign rf_rd_sel_o   = op_i[SEL_W-1:0];
   assign mem_addr_o    = addr_q;
   assign mem_rd_en_o   = (state == ST_READ);
   assign mem_wr_en_o   = (state == ST_WMEM);
   assign mem_wr_data_o = res_q;
   assign rf_wr_en_o    = (state == ST_WREG);
   assign rf_wr_sel_o   = op_q[SEL_W-1:0];
   assign rf_wr_data_o  = res_q;
   assign done_o        = (state == ST_DONE);

endmodule

// File: rtl/rsb_exec_unit_chk.sv
module rsb_exec_unit_chk #(
   parameter int ADDR_W = 16,
   parameter int SEL_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              done,
   input logic              mem_rd_en,
   input logic              mem_wr_en,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              rf_wr_en,
   input logic [SEL_W-1:0]  rf_wr_sel,
   input logic [7:0]        op_q
);

   AST_RESET_IDLE: assert property (@(posedge clk)
      !rst_n |-> (!busy && !done && !mem_wr_en && !rf_wr_en)); // R11

   AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd_en && mem_wr_en)); // R9

   AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |-> ($past(mem_rd_en, 2) && mem_addr == $past(mem_addr, 2))); // R6

   AST_RFWR_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      rf_wr_en |=> done); // R9

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R9

   AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy); // R10

   AST_RF_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      rf_wr_en |-> (rf_wr_sel != 3'b110)); // R5

   AST_BIT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && op_q[7:6] == 2'b01) |-> (!mem_wr_en && !rf_wr_en)); // R8

endmodule

bind rsb_exec_unit rsb_exec_unit_chk #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy_o),
   .done      (done_o),
   .mem_rd_en (mem_rd_en_o),
   .mem_wr_en (mem_wr_en_o),
   .mem_addr  (mem_addr_o),
   .rf_wr_en  (rf_wr_en_o),
   .rf_wr_sel (rf_wr_sel_o),
   .op_q      (op_q)
);

// File: tb/rsb_exec_unit_tb_top.sv
`timescale 1ns/1ps
module rsb_exec_unit_tb_top;

   localparam logic [15:0] HL_V = 16'h3410;
   localparam logic [15:0] IX_V = 16'h20F0;
   localparam logic [15:0] IY_V = 16'hFFF0;

   typedef struct packed {
      logic [7:0] op;
      logic [1:0] pfx;
      logic [7:0] disp;
      logic [7:0] din;
      logic       cin;
      logic [7:0] eres;
      logic       ec;
      logic       ez;
      logic [1:0] fchk;   // bit1 check carry, bit0 check zero
   } vec_t;

   localparam int NV = 16;
   localparam vec_t VECS [NV] = '{
      {8'h00, 2'd0, 8'h00, 8'h81, 1'b0, 8'h03, 1'b1, 1'b0, 2'b11},
      {8'h0F, 2'd0, 8'h00, 8'h01, 1'b0, 8'h80, 1'b1, 1'b0, 2'b11},
      {8'h16, 2'd0, 8'h7F, 8'h80, 1'b0, 8'h00, 1'b1, 1'b1, 2'b11},
      {8'h19, 2'd0, 8'h00, 8'h02, 1'b1, 8'h81, 1'b0, 1'b0, 2'b11},
      {8'h22, 2'd0, 8'h00, 8'hC1, 1'b0, 8'h82, 1'b1, 1'b0, 2'b11},
      {8'h2F, 2'd0, 8'h00, 8'h81, 1'b0, 8'hC0, 1'b1, 1'b0, 2'b11},
      {8'h37, 2'd0, 8'h00, 8'h80, 1'b0, 8'h01, 1'b1, 1'b0, 2'b11},
      {8'h3E, 2'd0, 8'h00, 8'h01, 1'b0, 8'h00, 1'b1, 1'b1, 2'b11},
      {8'h06, 2'd1, 8'h05, 8'h40, 1'b0, 8'h80, 1'b0, 1'b0, 2'b11},
      {8'h00, 2'd1, 8'hFE, 8'h81, 1'b0, 8'h03, 1'b1, 1'b0, 2'b11},
      {8'hC7, 2'd2, 8'h20, 8'h10, 1'b0, 8'h11, 1'b0, 1'b0, 2'b00},
      {8'h8A, 2'd1, 8'h03, 8'hFF, 1'b0, 8'hFD, 1'b0, 1'b0, 2'b00},
      {8'h7A, 2'd1, 8'h01, 8'h7F, 1'b0, 8'h00, 1'b0, 1'b1, 2'b01},
      {8'h46, 2'd0, 8'h00, 8'h01, 1'b0, 8'h00, 1'b0, 1'b0, 2'b01},
      {8'h35, 2'd2, 8'hFF, 8'h00, 1'b0, 8'h01, 1'b0, 1'b0, 2'b11},
      {8'h15, 2'd0, 8'h00, 8'h00, 1'b1, 8'h01, 1'b0, 1'b0, 2'b11}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [7:0]  op_i = '0;
   logic [1:0]  pfx_i = '0;
   logic [7:0]  disp_i = '0;
   logic        c_i = 1'b0;
   logic [2:0]  rf_rd_sel_o;
   logic [7:0]  rf_rd_data_i;
   logic [15:0] mem_addr_o;
   logic        mem_rd_en_o;
   logic [7:0]  mem_rd_data_i = '0;
   logic        mem_wr_en_o;
   logic [7:0]  mem_wr_data_o;
   logic        rf_wr_en_o;
   logic [2:0]  rf_wr_sel_o;
   logic [7:0]  rf_wr_data_o;
   logic        busy_o, done_o, flag_c_o, flag_z_o;

   logic [7:0]  mem  [0:255];
   logic [7:0]  regs [0:7];
   logic        rom = 1'b0;
   int          nchk = 0, nerr = 0, cyc = 0;
   int          rd_cnt, wr_cnt, rf_cnt, done_cnt, rd_cyc, wr_cyc, rf_cyc;
   logic [15:0] last_rd_addr, last_wr_addr;
   logic [2:0]  last_rf_sel;
   logic [7:0]  last_rf_data;

   always #4 clk = ~clk;

   assign rf_rd_data_i = regs[rf_rd_sel_o];

   rsb_exec_unit dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .pfx_i(pfx_i),
      .disp_i(disp_i), .hl_i(HL_V), .ix_i(IX_V), .iy_i(IY_V), .c_i(c_i),
      .rf_rd_sel_o(rf_rd_sel_o), .rf_rd_data_i(rf_rd_data_i),
      .mem_addr_o(mem_addr_o), .mem_rd_en_o(mem_rd_en_o), .mem_rd_data_i(mem_rd_data_i),
      .mem_wr_en_o(mem_wr_en_o), .mem_wr_data_o(mem_wr_data_o),
      .rf_wr_en_o(rf_wr_en_o), .rf_wr_sel_o(rf_wr_sel_o), .rf_wr_data_o(rf_wr_data_o),
      .busy_o(busy_o), .done_o(done_o), .flag_c_o(flag_c_o), .flag_z_o(flag_z_o)
   );

   // memory and register-file models
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (mem_rd_en_o) begin
         mem_rd_data_i <= mem[mem_addr_o[7:0]];
         rd_cnt <= rd_cnt + 1; rd_cyc <= cyc; last_rd_addr <= mem_addr_o;
      end
      if (mem_wr_en_o) begin
         if (!rom) mem[mem_addr_o[7:0]] <= mem_wr_data_o;
         wr_cnt <= wr_cnt + 1; wr_cyc <= cyc; last_wr_addr <= mem_addr_o;
      end
      if (rf_wr_en_o) begin
         regs[rf_wr_sel_o] <= rf_wr_data_o;
         rf_cnt <= rf_cnt + 1; rf_cyc <= cyc;
         last_rf_sel <= rf_wr_sel_o; last_rf_data <= rf_wr_data_o;
      end
      if (done_o) done_cnt <= done_cnt + 1;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_addr(input logic [1:0] pfx, input logic [7:0] disp);
      logic [15:0] sx = {{8{disp[7]}}, disp};
      case (pfx)
         2'd1:    return IX_V + sx;
         2'd2:    return IY_V + sx;
         default: return HL_V;
      endcase
   endfunction

   task automatic clr_counts();
      rd_cnt = 0; wr_cnt = 0; rf_cnt = 0; done_cnt = 0;
      rd_cyc = -1; wr_cyc = -1; rf_cyc = -1;
   endtask

   task automatic issue(input logic [7:0] op, input logic [1:0] pfx,
                        input logic [7:0] disp, input logic cin);
      @(negedge clk);
      op_i = op; pfx_i = pfx; disp_i = disp; c_i = cin; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic wait_done(input string tag);
      for (int i = 0; i < 40; i++) begin
         if (done_o) break;
         @(negedge clk);
      end
      chk({tag, " R9 done reached"}, done_o, 1'b1);
      @(negedge clk);
      chk({tag, " R9 done one cycle"}, {done_o, 8'(done_cnt)}, {1'b0, 8'd1});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 8'h00;
      for (int i = 0; i < 8; i++) regs[i] = 8'hA0 + 8'(i);
      clr_counts();
      repeat (3) @(negedge clk);
      // R11 reset state
      chk("R11 busy/done/wr in reset", {busy_o, done_o, mem_wr_en_o, rf_wr_en_o}, 4'b0000);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11 idle after reset", {busy_o, done_o, mem_rd_en_o, mem_wr_en_o, rf_wr_en_o}, 5'b0);

      // vector table
      for (int v = 0; v < NV; v++) begin
         vec_t   t = VECS[v];
         logic   memop = (t.pfx != 2'd0) || (t.op[2:0] == 3'b110);
         logic   istest = (t.op[7:6] == 2'b01);
         logic [15:0] ea = exp_addr(t.pfx, t.disp);
         string  tg = $sformatf("vec%0d", v);
         if (memop) mem[ea[7:0]] = t.din; else regs[t.op[2:0]] = t.din;
         clr_counts();
         issue(t.op, t.pfx, t.disp, t.cin);
         wait_done(tg);
         if (memop) begin
            chk({tg, " R4 R3 read address"}, last_rd_addr, ea);
            chk({tg, " R6 single read"}, rd_cnt, 1);
         end
         if (istest) begin
            chk({tg, " R8 no writes"}, {8'(wr_cnt), 8'(rf_cnt)}, 16'h0);
         end else if (memop) begin
            chk({tg, " R4 write address"}, last_wr_addr, ea);
            chk({tg, " R1 R7 memory result"}, mem[ea[7:0]], t.eres);
            if (t.pfx != 2'd0 && t.op[2:0] != 3'b110) begin
               chk({tg, " R5 register copy"}, {8'(rf_cnt), 5'(last_rf_sel), last_rf_data},
                   {8'd1, 5'(t.op[2:0]), t.eres});
               chk({tg, " R9 order"}, (rd_cyc < wr_cyc) && (wr_cyc < rf_cyc), 1'b1);
            end else begin
               chk({tg, " R5 R3 no register copy"}, rf_cnt, 0);
               chk({tg, " R9 order"}, rd_cyc < wr_cyc, 1'b1);
            end
         end else begin
            chk({tg, " R3 register write-back"}, {8'(rf_cnt), 5'(last_rf_sel), regs[t.op[2:0]]},
                {8'd1, 5'(t.op[2:0]), t.eres});
            chk({tg, " R3 no memory access"}, {8'(wr_cnt), 8'(rd_cnt)}, 16'h0);
         end
         if (t.fchk[1]) chk({tg, " R1 carry"}, flag_c_o, t.ec);
         if (t.fchk[0]) chk({tg, " R2 zero"}, flag_z_o, t.ez);
      end

      // R6: memory ignores the write, register copy still holds the result
      rom = 1'b1;
      mem[IX_V[7:0]] = 8'h81;
      clr_counts();
      issue(8'h00, 2'd1, 8'h00, 1'b0);
      wait_done("rom");
      chk("R6 copy despite ignored write", regs[0], 8'h03);
      chk("R6 memory untouched", mem[IX_V[7:0]], 8'h81);
      chk("R6 one read", rd_cnt, 1);
      rom = 1'b0;

      // R8: all eight low-bit variants of an indexed bit test
      for (int k = 0; k < 8; k++) begin
         mem[8'hF4] = 8'h08;  // IY-12 -> FFE4? use disp giving low byte F4
         clr_counts();
         issue(8'h58 | 8'(k), 2'd2, 8'h04, 1'b0);   // BIT 3,(IY+4)
         wait_done($sformatf("bitvar%0d", k));
         chk($sformatf("R8 variant %0d zero", k), flag_z_o, 1'b0);
         chk($sformatf("R8 variant %0d no writes", k), {8'(wr_cnt), 8'(rf_cnt)}, 16'h0);
      end

      // R10: start held while busy with a different opcode is ignored
      mem[IX_V[7:0]] = 8'h02;
      regs[7] = 8'h00;
      clr_counts();
      @(negedge clk);
      op_i = 8'h0E; pfx_i = 2'd1; disp_i = 8'h00; c_i = 1'b0; start_i = 1'b1;
      @(negedge clk);
      op_i = 8'hFF; pfx_i = 2'd0;
      repeat (2) @(negedge clk);
      start_i = 1'b0;
      wait_done("busy");
      repeat (3) @(negedge clk);
      chk("R10 first op result", mem[IX_V[7:0]], 8'h01);
      chk("R10 second start ignored", {8'(done_cnt), 8'(wr_cnt), 8'(rf_cnt), regs[7]},
          {8'd1, 8'd1, 8'd0, 8'h00});
      chk("R10 idle afterwards", busy_o, 1'b0);

      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

endmodule